// File: doc/BRIEF.md
# Card Host Interrupt Status Unit

This unit gathers the interrupt sources of a memory-card host controller into two 32-bit status words and raises a single interrupt line. The first word covers command and card events. The second word covers buffer handshakes and error causes. The command engine, the data engine and the card bus are outside the unit. They deliver one-cycle event pulses, buffer-state levels and live line levels. Each event pulse sets a sticky flag that stays set until software removes it.

Software reads both words and the two mask words over a plain register port. It removes flags by writing zeros: a zero clears a flag, a one leaves it alone. The buffer-ready flags are captured on the rising edge of the buffer state, not copied from its level. Software can therefore clear such a flag first and then drain or fill the buffer, and the flag will not come back until the next fill or empty. Live levels (card present, DAT0, command busy) sit in the same words as the sticky flags. They always show the current input and never raise the interrupt.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset, every sticky flag reads 0 and `irq` is 0.
- R2: The first status word is at byte offset 0x38. Bit 0 is response done and bit 2 is data done. Bit 3 is card removed and bit 4 is card inserted. Bit 5 is the live card-present level. Every other bit reads 0.
- R3: The second status word is at byte offset 0x3C. Bit 15 is illegal access and bit 14 is the live command-busy level. Bit 9 is write buffer ready, bit 8 is read buffer ready and bit 7 is the live DAT0 level. Bits 6..0 are the error causes taken from `ev_err_cause[6:0]` at the same positions: 6 response timeout, 5 illegal read, 4 illegal write, 3 data timeout, 2 end-bit error, 1 CRC error, 0 command index error. Bits 13..10 and 31..16 read 0.
- R4: A write to a status word clears each sticky bit written as 0 and keeps each sticky bit written as 1.
- R5: An event pulse that arrives in the same cycle as a clearing write leaves its flag set.
- R6: Writes never change the live level bits. A read always shows the level present in the read cycle.
- R7: Read buffer ready is set only by a rising edge of `rbuf_full`. After a clear it stays 0 for as long as `rbuf_full` stays high, and it sets again on the next rising edge.
- R8: Write buffer ready follows the same edge rule, driven by `wbuf_room`.
- R9: `irq` is 1 exactly when some sticky flag has its mask bit at 0. It changes in the same cycle as the status word it reflects, one cycle after the causing edge. Live level bits never drive it.
- R10: The mask words are at offsets 0x40 (first word) and 0x44 (second word). They can be read and written across the full width and reset to all ones.
- R11: Read data is registered and appears the cycle after the read request. It holds until the next read. A read never changes any flag. Unknown offsets read 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ev_rsp_done | input | 1 | Response complete pulse |
| ev_data_done | input | 1 | Data complete pulse |
| ev_card_in | input | 1 | Card inserted pulse |
| ev_card_out | input | 1 | Card removed pulse |
| ev_err_access | input | 1 | Illegal access pulse |
| ev_err_cause | input | 7 | Error cause pulses, positions as in R3 |
| rbuf_full | input | 1 | Read buffer holds a block (level) |
| wbuf_room | input | 1 | Write buffer can take a block (level) |
| lvl_card | input | 1 | Live card-present level |
| lvl_dat0 | input | 1 | Live DAT0 level |
| lvl_cmd_busy | input | 1 | Live command-busy level |
| irq | output | 1 | Masked interrupt request |

## Verification
Every flag is visible on `irq` and on the read port. A flag that is wrongly set or lost therefore shows up as a wrong `irq` on the next cycle whenever its mask bit is 0, or as a wrong value in the next read. A stale edge detector shows up only later: as a missing buffer-ready flag on the next fill, or as a flag coming back by itself while the buffer level stays high. The bench therefore holds `rbuf_full` and `wbuf_room` high across clears. A fault in the write decode (keep versus clear, or event priority) corrupts a flag the cycle after the write, and the next read of that word exposes it.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

  // byte offsets decoded by the register port
  localparam int unsigned OFS_ST1 = 32'h38;
  localparam int unsigned OFS_ST2 = 32'h3C;
  localparam int unsigned OFS_MK1 = 32'h40;
  localparam int unsigned OFS_MK2 = 32'h44;

  // first status word bit positions
  localparam int B1_RSP  = 0;
  localparam int B1_DATA = 2;
  localparam int B1_OUT  = 3;
  localparam int B1_IN   = 4;
  localparam int B1_CD   = 5;

  // second status word bit positions
  localparam int B2_DAT0 = 7;
  localparam int B2_RBUF = 8;
  localparam int B2_WBUF = 9;
  localparam int B2_BUSY = 14;
  localparam int B2_ILA  = 15;
  localparam int NUM_ERR = 7;

  // which bits hold sticky state
  localparam logic [31:0] STK1_KEEP = 32'h0000_001D;
  localparam logic [31:0] STK2_KEEP = 32'h0000_837F;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_ST1,
    RS_ST2,
    RS_MK1,
    RS_MK2
  } regsel_e;

endpackage

// File: rtl/sdh_irq_edge.sv
module sdh_irq_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  for (genvar i = 0; i < W; i++) begin : g_det
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q;
  end

endmodule

// File: rtl/sdh_irq_sticky.sv
module sdh_irq_sticky #(
  parameter int           W    = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_en,
  input  logic [W-1:0] clr_data,
  input  logic [W-1:0] set,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);

  logic [W-1:0] kept;

  // zero clears, one keeps; a set in the same cycle takes priority
  always_comb begin
    kept = clr_en ? (q & clr_data) : q;
    nxt  = (kept | set) & KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

endmodule

// File: rtl/sdh_irq_decode.sv
module sdh_irq_decode
  import sdh_irq_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int unsigned ST1_ADDR = OFS_ST1,
  parameter int unsigned ST2_ADDR = OFS_ST2,
  parameter int unsigned MK1_ADDR = OFS_MK1,
  parameter int unsigned MK2_ADDR = OFS_MK2
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output regsel_e           rsel,
  output logic              rd_en,
  output logic              wr_st1,
  output logic              wr_st2,
  output logic              wr_mk1,
  output logic              wr_mk2
);

  localparam logic [ADDR_W-1:0] A_ST1 = ADDR_W'(ST1_ADDR);
  localparam logic [ADDR_W-1:0] A_ST2 = ADDR_W'(ST2_ADDR);
  localparam logic [ADDR_W-1:0] A_MK1 = ADDR_W'(MK1_ADDR);
  localparam logic [ADDR_W-1:0] A_MK2 = ADDR_W'(MK2_ADDR);

  always_comb begin
    if      (addr == A_ST1) rsel = RS_ST1;
    else if (addr == A_ST2) rsel = RS_ST2;
    else if (addr == A_MK1) rsel = RS_MK1;
    else if (addr == A_MK2) rsel = RS_MK2;
    else                    rsel = RS_NONE;
  end

  assign rd_en  = sel & ~we;
  assign wr_st1 = sel & we & (rsel == RS_ST1);
  assign wr_st2 = sel & we & (rsel == RS_ST2);
  assign wr_mk1 = sel & we & (rsel == RS_MK1);
  assign wr_mk2 = sel & we & (rsel == RS_MK2);

endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 8,
  parameter int unsigned ST1_ADDR = OFS_ST1,
  parameter int unsigned ST2_ADDR = OFS_ST2,
  parameter int unsigned MK1_ADDR = OFS_MK1,
  parameter int unsigned MK2_ADDR = OFS_MK2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_rsp_done,
  input  logic              ev_data_done,
  input  logic              ev_card_in,
  input  logic              ev_card_out,
  input  logic              ev_err_access,
  input  logic [NUM_ERR-1:0] ev_err_cause,
  input  logic              rbuf_full,
  input  logic              wbuf_room,
  input  logic              lvl_card,
  input  logic              lvl_dat0,
  input  logic              lvl_cmd_busy,
  output logic              irq
);

  localparam logic [DATA_W-1:0] KEEP1 = DATA_W'(STK1_KEEP);
  localparam logic [DATA_W-1:0] KEEP2 = DATA_W'(STK2_KEEP);
  localparam int NUM_MASK = 2;

  regsel_e     rsel;
  logic        rd_en, wr_st1, wr_st2, wr_mk1, wr_mk2;
  logic [1:0]  buf_rise;
  logic [DATA_W-1:0] set1, set2;
  logic [DATA_W-1:0] st1_q, st1_nxt, st2_q, st2_nxt;
  logic [DATA_W-1:0] mk_q   [NUM_MASK];
  logic [DATA_W-1:0] mk_nxt [NUM_MASK];
  logic [NUM_MASK-1:0] wr_mk;
  logic [DATA_W-1:0] live1, live2, rd_val;

  sdh_irq_decode #(
    .ADDR_W(ADDR_W), .ST1_ADDR(ST1_ADDR), .ST2_ADDR(ST2_ADDR),
    .MK1_ADDR(MK1_ADDR), .MK2_ADDR(MK2_ADDR)
  ) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .rsel(rsel), .rd_en(rd_en),
    .wr_st1(wr_st1), .wr_st2(wr_st2), .wr_mk1(wr_mk1), .wr_mk2(wr_mk2)
  );

  // bit 0 = read buffer filled, bit 1 = write buffer emptied
  sdh_irq_edge #(.W(2)) u_edge (
    .clk(clk), .rst(rst), .lvl({wbuf_room, rbuf_full}), .rise(buf_rise)
  );

  assign set1 = DATA_W'({ev_card_in, ev_card_out, ev_data_done, 1'b0, ev_rsp_done});
  assign set2 = DATA_W'({ev_err_access, 5'b0, buf_rise[1], buf_rise[0], 1'b0, ev_err_cause});

  sdh_irq_sticky #(.W(DATA_W), .KEEP(KEEP1)) u_st1 (
    .clk(clk), .rst(rst), .clr_en(wr_st1), .clr_data(bus_wdata),
    .set(set1), .q(st1_q), .nxt(st1_nxt)
  );

  sdh_irq_sticky #(.W(DATA_W), .KEEP(KEEP2)) u_st2 (
    .clk(clk), .rst(rst), .clr_en(wr_st2), .clr_data(bus_wdata),
    .set(set2), .q(st2_q), .nxt(st2_nxt)
  );

  assign wr_mk = {wr_mk2, wr_mk1};

  for (genvar m = 0; m < NUM_MASK; m++) begin : g_mask
    assign mk_nxt[m] = wr_mk[m] ? bus_wdata : mk_q[m];
    always_ff @(posedge clk) begin
      if (rst) mk_q[m] <= '1;
      else     mk_q[m] <= mk_nxt[m];
    end
  end

  // live levels join the sticky bits only on the read path
  assign live1 = DATA_W'(lvl_card) << B1_CD;
  assign live2 = (DATA_W'(lvl_cmd_busy) << B2_BUSY) | (DATA_W'(lvl_dat0) << B2_DAT0);

  always_comb begin
    unique case (rsel)
      RS_ST1:  rd_val = st1_q | live1;
      RS_ST2:  rd_val = st2_q | live2;
      RS_MK1:  rd_val = mk_q[0];
      RS_MK2:  rd_val = mk_q[1];
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_val;
  end

  // built from next-state so irq lines up with the status registers
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (|(st1_nxt & ~mk_nxt[0])) | (|(st2_nxt & ~mk_nxt[1]));
  end

endmodule

// File: rtl/sdh_irq_chk.sv
module sdh_irq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_st1,
  input logic [3:0]        ev1,
  input logic              ev_rsp_done,
  input logic              rbuf_full,
  input logic [DATA_W-1:0] st1_q,
  input logic [DATA_W-1:0] st2_q,
  input logic [DATA_W-1:0] mk1_q,
  input logic [DATA_W-1:0] mk2_q,
  input logic              irq
);

  AST_MASKS_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mk1_q && &mk2_q)); // R10

  AST_ST1_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_st1 && ev1 == 4'b0) |=> $stable(st1_q)); // R4

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_st1 && ev_rsp_done) |=> st1_q[0]); // R5

  AST_RBUF_NO_REARM: assert property (@(posedge clk) disable iff (rst)
    (rbuf_full && $past(rbuf_full) && !st2_q[8]) |=> !st2_q[8]); // R7

  AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (&mk1_q && &mk2_q) |-> !irq); // R9

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((st1_q & ~mk1_q) != '0 || (st2_q & ~mk2_q) != '0)); // R9

endmodule

bind sdh_irq_status sdh_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .wr_st1(wr_st1),
  .ev1({ev_card_in, ev_card_out, ev_data_done, ev_rsp_done}),
  .ev_rsp_done(ev_rsp_done),
  .rbuf_full(rbuf_full),
  .st1_q(st1_q),
  .st2_q(st2_q),
  .mk1_q(mk_q[0]),
  .mk2_q(mk_q[1]),
  .irq(irq)
);

// File: tb/test_sdh_irq_status.sv
module test_sdh_irq_status;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        ev_rsp_done = 0, ev_data_done = 0, ev_card_in = 0, ev_card_out = 0;
  logic        ev_err_access = 0;
  logic [6:0]  ev_err_cause = 0;
  logic        rbuf_full = 0, wbuf_room = 0;
  logic        lvl_card = 0, lvl_dat0 = 0, lvl_cmd_busy = 0;
  logic        irq;

  always #2 clk = ~clk;

  sdh_irq_status i_sdh_irq_status (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_rsp_done(ev_rsp_done),
    .ev_data_done(ev_data_done), .ev_card_in(ev_card_in), .ev_card_out(ev_card_out),
    .ev_err_access(ev_err_access), .ev_err_cause(ev_err_cause), .rbuf_full(rbuf_full),
    .wbuf_room(wbuf_room), .lvl_card(lvl_card), .lvl_dat0(lvl_dat0),
    .lvl_cmd_busy(lvl_cmd_busy), .irq(irq)
  );

  int    vectors = 0, miscompares = 0;
  bit    done = 0;
  string cur_tag = "R11";

  // behavioural reference state
  logic [31:0] m_st1, m_st2, m_mk1, m_mk2, m_rdata;
  logic        m_prev_r, m_prev_w, m_irq;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] e1, e2, rv;
    bit r_rise, w_rise;
    if (rst) begin
      m_st1 = 0; m_st2 = 0; m_mk1 = '1; m_mk2 = '1; m_rdata = 0;
      m_prev_r = 0; m_prev_w = 0; m_irq = 0;
      return;
    end
    r_rise = rbuf_full && !m_prev_r;
    w_rise = wbuf_room && !m_prev_w;
    m_prev_r = rbuf_full; m_prev_w = wbuf_room;
    e1 = 0; e2 = 0;
    if (ev_rsp_done)  e1 += 32'h01;
    if (ev_data_done) e1 += 32'h04;
    if (ev_card_out)  e1 += 32'h08;
    if (ev_card_in)   e1 += 32'h10;
    if (ev_err_access) e2 += 32'h8000;
    if (w_rise) e2 += 32'h200;
    if (r_rise) e2 += 32'h100;
    e2 += {25'b0, ev_err_cause};
    rv = 0;
    case (bus_addr)
      8'h38: rv = m_st1 + (lvl_card ? 32'h20 : 0);
      8'h3C: rv = m_st2 + (lvl_cmd_busy ? 32'h4000 : 0) + (lvl_dat0 ? 32'h80 : 0);
      8'h40: rv = m_mk1;
      8'h44: rv = m_mk2;
      default: rv = 0;
    endcase
    if (bus_sel && !bus_we) m_rdata = rv;
    if (bus_sel && bus_we) begin
      case (bus_addr)
        8'h38: m_st1 = m_st1 & bus_wdata;
        8'h3C: m_st2 = m_st2 & bus_wdata;
        8'h40: m_mk1 = bus_wdata;
        8'h44: m_mk2 = bus_wdata;
        default: ;
      endcase
    end
    m_st1 = m_st1 | e1;
    m_st2 = m_st2 | e2;
    m_irq = ((m_st1 & ~m_mk1) != 0) || ((m_st2 & ~m_mk2) != 0);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (!rst) begin
      chk(cur_tag, bus_rdata, m_rdata);
      chk("R9", {31'b0, irq}, {31'b0, m_irq});
    end
  endtask

  task automatic clear_events();
    ev_rsp_done = 0; ev_data_done = 0; ev_card_in = 0; ev_card_out = 0;
    ev_err_access = 0; ev_err_cause = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_sel = 0; bus_we = 0;
    clear_events();
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    cyc();
    bus_sel = 0;
    clear_events();
    v = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      cyc();
      clear_events();
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) cyc();
    @(negedge clk); rst = 0;

    // reset state
    cur_tag = "R1";
    rd(8'h38, v); chk("R1", v, 32'h0);
    rd(8'h3C, v); chk("R1", v, 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);
    cur_tag = "R10";
    rd(8'h40, v); chk("R10", v, 32'hFFFF_FFFF);
    rd(8'h44, v); chk("R10", v, 32'hFFFF_FFFF);

    // first word layout
    cur_tag = "R2";
    lvl_card = 1;
    ev_rsp_done = 1; ev_data_done = 1; ev_card_in = 1; ev_card_out = 1;
    idle(1);
    rd(8'h38, v); chk("R2", v, 32'h3D);

    // second word layout
    cur_tag = "R3";
    ev_err_access = 1; ev_err_cause = 7'h7F; rbuf_full = 1; wbuf_room = 1;
    lvl_cmd_busy = 1; lvl_dat0 = 1;
    idle(1);
    rd(8'h3C, v); chk("R3", v, 32'hC3FF);

    // zero clears, one keeps
    cur_tag = "R4";
    wr(8'h38, 32'h11);
    rd(8'h38, v); chk("R4", v, 32'h31);

    // live bits survive a clear of the second word
    cur_tag = "R6";
    wr(8'h3C, 32'h0);
    rd(8'h3C, v); chk("R6", v, 32'h4080);
    lvl_dat0 = 0;
    rd(8'h3C, v); chk("R6", v, 32'h4000);

    // buffer levels still high: flags must stay clear
    cur_tag = "R7";
    idle(4);
    rd(8'h3C, v); chk("R7", v[8] ? 32'h1 : 32'h0, 32'h0);
    rbuf_full = 0; idle(2); rbuf_full = 1; idle(1);
    rd(8'h3C, v); chk("R7", v, 32'h4100);
    cur_tag = "R8";
    wr(8'h3C, 32'h0);
    wbuf_room = 0; idle(1); wbuf_room = 1; idle(3);
    rd(8'h3C, v); chk("R8", v, 32'h4200);
    wr(8'h3C, 32'h0); idle(3);
    rd(8'h3C, v); chk("R8", v, 32'h4000);

    // event during a clearing write
    cur_tag = "R5";
    ev_data_done = 1;
    wr(8'h38, 32'h0);
    rd(8'h38, v); chk("R5", v, 32'h24);

    // interrupt masking
    cur_tag = "R9";
    wr(8'h40, 32'hFFFF_FFFB);
    chk("R9", {31'b0, irq}, 32'h1);
    wr(8'h38, 32'h0);
    chk("R9", {31'b0, irq}, 32'h0);
    wr(8'h44, 32'h0);
    lvl_cmd_busy = 1; lvl_dat0 = 1; idle(2);
    chk("R9", {31'b0, irq}, 32'h0);
    ev_err_cause = 7'h02; idle(1);
    chk("R9", {31'b0, irq}, 32'h1);
    wr(8'h3C, 32'hFFFF_FFFD);
    chk("R9", {31'b0, irq}, 32'h0);

    // registered read port, no read side effect, unknown offsets
    cur_tag = "R11";
    ev_card_in = 1; idle(1);
    rd(8'h38, v); chk("R11", v, 32'h30);
    idle(3); chk("R11", bus_rdata, 32'h30);
    rd(8'h38, v); chk("R11", v, 32'h30);
    wr(8'h48, 32'h0);
    rd(8'h48, v); chk("R11", v, 32'h0);
    rd(8'h38, v); chk("R11", v, 32'h30);
    cur_tag = "R10";
    wr(8'h44, 32'hA5A5_5A5A);
    rd(8'h44, v); chk("R10", v, 32'hA5A5_5A5A);

    // mixed stimulus against the reference model
    cur_tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      int p;
      p = $urandom_range(0, 99);
      ev_rsp_done   = ($urandom_range(0, 15) == 0);
      ev_data_done  = ($urandom_range(0, 15) == 0);
      ev_card_in    = ($urandom_range(0, 31) == 0);
      ev_card_out   = ($urandom_range(0, 31) == 0);
      ev_err_access = ($urandom_range(0, 31) == 0);
      ev_err_cause  = ($urandom_range(0, 7) == 0) ? 7'($urandom) : 7'h0;
      if ($urandom_range(0, 9) == 0) rbuf_full = ~rbuf_full;
      if ($urandom_range(0, 9) == 0) wbuf_room = ~wbuf_room;
      lvl_card = $urandom_range(0, 1); lvl_dat0 = $urandom_range(0, 1);
      lvl_cmd_busy = $urandom_range(0, 1);
      bus_sel = (p < 50); bus_we = (p < 20);
      case ($urandom_range(0, 4))
        0: bus_addr = 8'h38;
        1: bus_addr = 8'h3C;
        2: bus_addr = 8'h40;
        3: bus_addr = 8'h44;
        default: bus_addr = 8'($urandom);
      endcase
      bus_wdata = $urandom;
      if (bus_addr == 8'h40 || bus_addr == 8'h44) bus_wdata = bus_wdata | 32'hFFFF_0F0F;
      cyc();
    end
    bus_sel = 0; clear_events();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule